// File: doc/BRIEF.md
# Truncating bfloat16 Adder/Subtractor

This block adds or subtracts two bfloat16 operands and hands back one bfloat16 result per clock. Each operand is a 16-bit word: a sign bit in bit 15, an 8-bit exponent with bias 127 in bits 14:7, and 7 stored fraction bits in bits 6:0. A leading 1 is implied for any non-zero exponent, which gives 8 bits of precision. The arithmetic core is combinational. A single result register and a valid flag sit at the output, so a new operation can start on every cycle.

The arithmetic is deliberately reduced. The only rounding is truncation toward zero, so the magnitude is never incremented. Any overflow saturates at the largest finite magnitude. An exponent field of zero is read as a zero, and results too small to normalize are flushed to a signed zero. Infinity and NaN encodings (exponent 255) must not be presented.

Internally the operands are ordered by magnitude. The datapath then splits into two parts. A close path handles effective subtractions whose exponents differ by less than two: it uses a leading-zero count and a left shift. A far path handles every other case: it uses an alignment shifter with guard and sticky bits and a one-position renormalization.

Top module: `bf16_trunc_adder`

## Requirements
- R1: With `sub_sel`=0 the result is the sum `op_a + op_b`, truncated toward zero to 8 significant bits and packed as sign bit 15, exponent bits 14:7 (bias 127), fraction bits 6:0. For example, 0x3F80+0x3F80 gives 0x4000.
- R2: Rounding truncates toward zero on both paths. The result magnitude never exceeds the exact magnitude, and discarded low bits never cause an increment. For example, 0x3F81+0x3B80 gives 0x3F81.
- R3: If the normalized exponent reaches 255 or more, the result is 0x7F7F with the result sign (0x7F7F or 0xFF7F). An exponent field of 255 never appears at the output.
- R4: If the normalized exponent is 0 or negative, the result is a zero that keeps the result sign (0x0000 or 0x8000).
- R5: When both operands are non-zero and their signed values cancel exactly, the result is +0 (0x0000).
- R6: When exactly one operand has a zero exponent field, the result is the other operand. `op_a` is passed through unchanged. `op_b` is passed with bit 15 inverted when `sub_sel`=1.
- R7: When both operands have a zero exponent field, the result is 0x8000 only if `op_a` bit 15 is 1 and the effective sign of `op_b` (bit 15 XOR `sub_sel`) is 1. Otherwise the result is 0x0000.
- R8: With `sub_sel`=1 the result is `op_a - op_b`, computed by inverting the sign of `op_b`, and truncated as in R2.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock. The result of an operation presented with `in_valid`=1 appears on `result` after that same edge.
- R10: A cycle with `in_valid`=0 leaves `result` unchanged.
- R11: While `rst_n` is low at a clock edge, `out_valid` and `result` clear to 0, whatever `in_valid` is.
- R12: When the exponent difference exceeds 9, an effective addition returns the larger operand unchanged. An effective subtraction returns the next representable magnitude below the larger operand, with that operand's sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and `sub_sel` are valid this cycle |
| op_a | input | 16 | First bfloat16 operand |
| op_b | input | 16 | Second bfloat16 operand |
| sub_sel | input | 1 | 0 computes a+b, 1 computes a-b |
| out_valid | output | 1 | `result` carries a new value this cycle |
| result | output | 16 | Registered bfloat16 result |

## Verification
The bench focuses on these corner cases:
- The boundaries between the two paths: exponent differences of 0, 1, 2, 10 and far beyond. A design that routed a difference of 1 to the far path, or dropped the sticky bit, would return the larger operand instead of its predecessor on subtraction.
- Truncation at the carry-out renormalization. Rounding to nearest here would produce one unit too many.
- Saturation at the top of the range. A missing clamp would leak an infinity encoding.
- Flushing at exponent 1. A missing flush would wrap the exponent into a huge value.
- The sign of every zero: exact cancellation, zero-plus-zero under each `sub_sel`, and negative underflow. Getting any of these wrong shows up as a flipped bit 15.

Random traffic weighted toward close exponents covers the leading-zero count across its whole range, with idle cycles mixed in to test the hold behaviour.

// File: rtl/bf16_add_pkg.sv
// Package: shared format constants and the operand word layout for the
// truncating bfloat16 adder. Assumes a normal-only format (no specials).
package bf16_add_pkg;

    parameter int unsigned EXP_W   = 8;
    parameter int unsigned FRAC_W  = 7;
    parameter int unsigned GUARD_W = 3;

    localparam int unsigned WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int unsigned SIG_W   = FRAC_W + 1;
    localparam int unsigned ES_W    = EXP_W + 2;
    localparam int unsigned EXP_MAX = (1 << EXP_W) - 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } bf16_t;

endpackage

// File: rtl/bf16_operand_order.sv
// Module: orders the two operands by magnitude, applies the subtract
// select to the second operand's sign, and picks close or far path.
// Assumes neither operand is zero when its outputs are used.
module bf16_operand_order
    import bf16_add_pkg::*;
(
    input  bf16_t                op_a,
    input  bf16_t                op_b,
    input  logic                 sub_sel,
    output logic                 big_sign,
    output logic [EXP_W-1:0]     big_exp,
    output logic [SIG_W-1:0]     big_sig,
    output logic [SIG_W-1:0]     small_sig,
    output logic [EXP_W-1:0]     exp_diff,
    output logic                 eff_sub,
    output logic                 b_eff_sign,
    output logic                 use_close
);

    logic             swap;
    logic [EXP_W-1:0] small_exp;

    // Effective signs, magnitude compare and swap.
    always_comb begin
        b_eff_sign = op_b.sign ^ sub_sel;
        swap       = {op_b.exp, op_b.frac} > {op_a.exp, op_a.frac};
        if (swap) begin
            big_sign  = b_eff_sign;
            big_exp   = op_b.exp;
            big_sig   = {1'b1, op_b.frac};
            small_exp = op_a.exp;
            small_sig = {1'b1, op_a.frac};
        end else begin
            big_sign  = op_a.sign;
            big_exp   = op_a.exp;
            big_sig   = {1'b1, op_a.frac};
            small_exp = op_b.exp;
            small_sig = {1'b1, op_b.frac};
        end
    end

    // Exponent gap and path choice.
    always_comb begin
        exp_diff  = big_exp - small_exp;
        eff_sub   = op_a.sign ^ b_eff_sign;
        use_close = eff_sub && (exp_diff < EXP_W'(2));
    end

endmodule

// File: rtl/bf16_far_path.sv
// Module: far path. Aligns the smaller significand with guard and sticky
// bits, adds or subtracts, and renormalizes by at most one position.
// Assumes the larger magnitude is on big_* and, for subtraction, that
// the exponent gap is at least 2 (otherwise the output is not used).
module bf16_far_path
    import bf16_add_pkg::*;
(
    input  logic [EXP_W-1:0]        big_exp,
    input  logic [SIG_W-1:0]        big_sig,
    input  logic [SIG_W-1:0]        small_sig,
    input  logic [EXP_W-1:0]        exp_diff,
    input  logic                    eff_sub,
    output logic [SIG_W-1:0]        res_sig,
    output logic signed [ES_W-1:0]  res_exp
);

    localparam int unsigned EXT_W  = SIG_W + GUARD_W;
    localparam int unsigned WIDE_W = 2 * EXT_W;
    localparam int unsigned SH_CAP = EXT_W + 1;
    localparam int unsigned SH_W   = $clog2(SH_CAP + 1);

    logic [SH_W-1:0]             sh;
    logic [WIDE_W-1:0]           wide;
    logic [EXT_W-1:0]            aligned;
    logic                        sticky;
    logic [EXT_W-1:0]            big_ext;
    logic [EXT_W:0]              sum;
    logic [EXT_W-1:0]            dif;
    logic signed [ES_W-1:0]      base_exp;

    // Alignment shift, capped so that a huge gap leaves only the sticky bit.
    always_comb begin
        sh      = (exp_diff > EXP_W'(EXT_W)) ? SH_W'(SH_CAP) : exp_diff[SH_W-1:0];
        wide    = {small_sig, {GUARD_W{1'b0}}, {EXT_W{1'b0}}} >> sh;
        aligned = wide[WIDE_W-1:EXT_W];
        sticky  = |wide[EXT_W-1:0];
    end

    // Magnitude add and sticky-aware subtract.
    always_comb begin
        big_ext  = {big_sig, {GUARD_W{1'b0}}};
        sum      = {1'b0, big_ext} + {1'b0, aligned};
        dif      = big_ext - aligned - EXT_W'(sticky);
        base_exp = $signed({2'b00, big_exp});
    end

    // One-position renormalization, low bits dropped (truncation).
    always_comb begin
        if (!eff_sub) begin
            if (sum[EXT_W]) begin
                res_sig = SIG_W'(sum >> (GUARD_W + 1));
                res_exp = base_exp + ES_W'(1);
            end else begin
                res_sig = SIG_W'(sum >> GUARD_W);
                res_exp = base_exp;
            end
        end else begin
            if (dif[EXT_W-1]) begin
                res_sig = SIG_W'(dif >> GUARD_W);
                res_exp = base_exp;
            end else begin
                res_sig = SIG_W'(dif >> (GUARD_W - 1));
                res_exp = base_exp - ES_W'(1);
            end
        end
    end

endmodule

// File: rtl/bf16_close_path.sv
// Module: close path. Exact subtraction for exponent gaps of 0 or 1,
// leading-zero count, left normalization and exponent decrement.
// Assumes an effective subtraction with the larger magnitude on big_*.
module bf16_close_path
    import bf16_add_pkg::*;
(
    input  logic [EXP_W-1:0]        big_exp,
    input  logic [SIG_W-1:0]        big_sig,
    input  logic [SIG_W-1:0]        small_sig,
    input  logic                    gap_one,
    output logic [SIG_W-1:0]        res_sig,
    output logic signed [ES_W-1:0]  res_exp,
    output logic                    res_zero
);

    localparam int unsigned DW   = SIG_W + 1;
    localparam int unsigned LZ_W = $clog2(DW + 1);

    logic [DW-1:0]   lhs;
    logic [DW-1:0]   rhs;
    logic [DW-1:0]   d;
    logic [LZ_W-1:0] lz;
    logic [DW-1:0]   norm;

    // Exact difference with one extra low bit for the one-position gap.
    always_comb begin
        lhs      = {big_sig, 1'b0};
        rhs      = gap_one ? {1'b0, small_sig} : {small_sig, 1'b0};
        d        = lhs - rhs;
        res_zero = (d == '0);
    end

    // Leading-zero count as a priority scan; highest set bit wins.
    always_comb begin
        lz = LZ_W'(DW);
        for (int i = 0; i < DW; i++) begin
            if (d[i]) lz = LZ_W'(DW - 1 - i);
        end
    end

    // Left normalization and exponent adjustment.
    always_comb begin
        norm    = d << lz;
        res_sig = SIG_W'(norm >> 1);
        res_exp = $signed({2'b00, big_exp}) - $signed({{(ES_W - LZ_W){1'b0}}, lz});
    end

endmodule

// File: rtl/bf16_trunc_adder.sv
// Module: top of the truncating bfloat16 adder/subtractor. Handles zero
// bypass, path select, saturation and flush, and registers the result.
// Assumes no operand carries the all-ones exponent (infinity/NaN).
module bf16_trunc_adder
    import bf16_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub_sel,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);

    localparam logic signed [ES_W-1:0] EXP_TOP  = ES_W'(EXP_MAX);
    localparam logic signed [ES_W-1:0] EXP_ZERO = '0;

    bf16_t                   a_w;
    bf16_t                   b_w;
    logic                    a_zero;
    logic                    b_zero;
    logic                    big_sign;
    logic [EXP_W-1:0]        big_exp;
    logic [SIG_W-1:0]        big_sig;
    logic [SIG_W-1:0]        small_sig;
    logic [EXP_W-1:0]        exp_diff;
    logic                    eff_sub;
    logic                    b_eff_sign;
    logic                    use_close;
    logic [SIG_W-1:0]        far_sig;
    logic signed [ES_W-1:0]  far_exp;
    logic [SIG_W-1:0]        close_sig;
    logic signed [ES_W-1:0]  close_exp;
    logic                    close_zero;
    logic [SIG_W-1:0]        sel_sig;
    logic signed [ES_W-1:0]  sel_exp;
    logic [WORD_W-1:0]       next_word;

    // Operand view and zero detection.
    always_comb begin
        a_w    = op_a;
        b_w    = op_b;
        a_zero = (a_w.exp == '0);
        b_zero = (b_w.exp == '0);
    end

    bf16_operand_order order_i (
        .op_a       (a_w),
        .op_b       (b_w),
        .sub_sel    (sub_sel),
        .big_sign   (big_sign),
        .big_exp    (big_exp),
        .big_sig    (big_sig),
        .small_sig  (small_sig),
        .exp_diff   (exp_diff),
        .eff_sub    (eff_sub),
        .b_eff_sign (b_eff_sign),
        .use_close  (use_close)
    );

    bf16_far_path far_i (
        .big_exp   (big_exp),
        .big_sig   (big_sig),
        .small_sig (small_sig),
        .exp_diff  (exp_diff),
        .eff_sub   (eff_sub),
        .res_sig   (far_sig),
        .res_exp   (far_exp)
    );

    bf16_close_path close_i (
        .big_exp   (big_exp),
        .big_sig   (big_sig),
        .small_sig (small_sig),
        .gap_one   (exp_diff[0]),
        .res_sig   (close_sig),
        .res_exp   (close_exp),
        .res_zero  (close_zero)
    );

    // Path merge, zero rules, saturation and flush.
    always_comb begin
        sel_sig = use_close ? close_sig : far_sig;
        sel_exp = use_close ? close_exp : far_exp;
        if (a_zero && b_zero) begin
            next_word = {a_w.sign & b_eff_sign, {(WORD_W-1){1'b0}}};
        end else if (a_zero) begin
            next_word = {b_eff_sign, op_b[WORD_W-2:0]};
        end else if (b_zero) begin
            next_word = op_a;
        end else if (use_close && close_zero) begin
            next_word = '0;
        end else if (sel_exp >= EXP_TOP) begin
            next_word = {big_sign, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
        end else if (sel_exp <= EXP_ZERO) begin
            next_word = {big_sign, {(WORD_W-1){1'b0}}};
        end else begin
            next_word = {big_sign, sel_exp[EXP_W-1:0], sel_sig[FRAC_W-1:0]};
        end
    end

    // Output register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_word;
        end
    end

    AST_VALID_LAG:  assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
    AST_HOLD_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R10
    AST_NO_INF:     assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (result[WORD_W-2:FRAC_W] != {EXP_W{1'b1}})); // R3
    AST_CANCEL_POS: assert property (@(posedge clk) disable iff (!rst_n)
                        (in_valid && !a_zero && !b_zero && use_close && close_zero) |=> (result == '0)); // R5
    AST_NORM_LEAD:  assert property (@(posedge clk) disable iff (!rst_n)
                        (in_valid && !a_zero && !b_zero && !(use_close && close_zero)) |-> sel_sig[SIG_W-1]); // R1

endmodule

// File: tb/bf16_trunc_adder_tb_top.sv
module bf16_trunc_adder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        sub_sel = 1'b0;
    logic        out_valid;
    logic [15:0] result;

    int          checks = 0;
    int          failures = 0;
    logic        exp_v = 1'b0;
    logic [15:0] exp_r = '0;
    string       exp_tag = "R11";

    always #2 clk = ~clk;

    bf16_trunc_adder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .sub_sel   (sub_sel),
        .out_valid (out_valid),
        .result    (result)
    );

    // Behavioural reference: exact integer sum, then truncation.
    function automatic logic [15:0] ref_add(logic [15:0] a, logic [15:0] b, logic sub);
        int     ea, eb, emin, da, db, p, e, el;
        logic   sa, sb, sl, ss, neg;
        longint ma, mb, va, vb, s, m, mant, ml;
        ea = int'(a[14:7]);
        eb = int'(b[14:7]);
        sa = a[15];
        sb = b[15] ^ sub;
        if (ea == 0 && eb == 0) return {sa & sb, 15'h0};
        if (ea == 0) return {sb, b[14:0]};
        if (eb == 0) return a;
        ma = longint'(a[6:0]) + 128;
        mb = longint'(b[6:0]) + 128;
        emin = (ea < eb) ? ea : eb;
        da = ea - emin;
        db = eb - emin;
        if (da > 40 || db > 40) begin
            if (da > db) begin el = ea; ml = ma; sl = sa; ss = sb; end
            else begin el = eb; ml = mb; sl = sb; ss = sa; end
            if (sl == ss) return {sl, el[7:0], ml[6:0]};
            if (ml == 128) begin el = el - 1; ml = 255; end
            else ml = ml - 1;
            if (el <= 0) return {sl, 15'h0};
            return {sl, el[7:0], ml[6:0]};
        end
        va = sa ? -(ma <<< da) : (ma <<< da);
        vb = sb ? -(mb <<< db) : (mb <<< db);
        s  = va + vb;
        if (s == 0) return 16'h0000;
        neg = (s < 0);
        m   = neg ? -s : s;
        p   = 0;
        for (int i = 0; i < 62; i++) if (((m >> i) & 1) == 1) p = i;
        e    = emin + p - 7;
        mant = (p >= 7) ? (m >> (p - 7)) : (m << (7 - p));
        if (e >= 255) return {neg, 8'hFE, 7'h7F};
        if (e <= 0) return {neg, 15'h0};
        return {neg, e[7:0], mant[6:0]};
    endfunction

    // One cycle: check the previous operation's outcome, then drive the next.
    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic sub,
                        input logic v, input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== exp_v || result !== exp_r) begin
            failures++;
            $display("FAIL %s: out_valid=%0b result=%h expected out_valid=%0b result=%h",
                     exp_tag, out_valid, result, exp_v, exp_r);
        end
        op_a     = a;
        op_b     = b;
        sub_sel  = sub;
        in_valid = v;
        exp_v    = v;
        if (v) exp_r = ref_add(a, b, sub);
        exp_tag  = v ? tag : "R10";
    endtask

    function automatic logic [15:0] rand_op(int e_base);
        int e;
        e = e_base + int'($urandom_range(6)) - 3;
        if (e < 1) e = 1;
        if (e > 254) e = 254;
        if ($urandom_range(19) == 0) e = 0;
        return {1'(($urandom_range(1))), 8'(e), 7'($urandom_range(127))};
    endfunction

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R11: reset dominates a valid input.
        in_valid = 1'b1;
        op_a = 16'h3F80;
        op_b = 16'h3F80;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 16'h0000) begin
            failures++;
            $display("FAIL R11: out_valid=%0b result=%h expected out_valid=0 result=0000", out_valid, result);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        step(16'h3F80, 16'h3F80, 1'b0, 1'b1, "R1");
        step(16'h3F80, 16'h3FC0, 1'b0, 1'b1, "R1");
        step(16'h4040, 16'h3F80, 1'b1, 1'b1, "R8");
        step(16'h3F81, 16'h3B80, 1'b0, 1'b1, "R2");
        step(16'h3FFF, 16'h3F80, 1'b0, 1'b1, "R2");
        step(16'h0000, 16'h0000, 1'b0, 1'b0, "R10");
        step(16'h1234, 16'h4321, 1'b1, 1'b0, "R10");
        step(16'h3F80, 16'h3000, 1'b0, 1'b1, "R12");
        step(16'h3F80, 16'h3000, 1'b1, 1'b1, "R12");
        step(16'h3F80, 16'h3A80, 1'b1, 1'b1, "R12");
        step(16'h3F80, 16'h3A80, 1'b0, 1'b1, "R12");
        step(16'h7F7F, 16'h7F7F, 1'b0, 1'b1, "R3");
        step(16'hFF7F, 16'hFF7F, 1'b0, 1'b1, "R3");
        step(16'h7F7F, 16'hFF7F, 1'b1, 1'b1, "R3");
        step(16'h8081, 16'h8080, 1'b1, 1'b1, "R4");
        step(16'h0080, 16'h0081, 1'b1, 1'b1, "R4");
        step(16'h0100, 16'h0080, 1'b1, 1'b1, "R4");
        step(16'h4040, 16'h4040, 1'b1, 1'b1, "R5");
        step(16'hC040, 16'hC040, 1'b1, 1'b1, "R5");
        step(16'h4040, 16'hC040, 1'b0, 1'b1, "R5");
        step(16'h0000, 16'h4040, 1'b0, 1'b1, "R6");
        step(16'h0000, 16'h4040, 1'b1, 1'b1, "R6");
        step(16'h4040, 16'h8000, 1'b1, 1'b1, "R6");
        step(16'h8000, 16'h8000, 1'b0, 1'b1, "R7");
        step(16'h8000, 16'h0000, 1'b1, 1'b1, "R7");
        step(16'h0000, 16'h8000, 1'b0, 1'b1, "R7");
        step(16'h8000, 16'h8000, 1'b1, 1'b1, "R7");
        step(16'h3F80, 16'h3F00, 1'b1, 1'b1, "R8");
        step(16'h3F81, 16'h3F80, 1'b1, 1'b1, "R8");
        step(16'h4001, 16'h3F81, 1'b1, 1'b1, "R8");

        // Mixed random traffic, weighted toward close exponents.
        for (int n = 0; n < 4000; n++) begin
            int          base;
            logic [15:0] ra, rb;
            base = int'($urandom_range(253)) + 1;
            ra = rand_op(base);
            rb = ($urandom_range(7) == 0) ? rand_op(int'($urandom_range(253)) + 1) : rand_op(base);
            step(ra, rb, 1'($urandom_range(1)), ($urandom_range(4) != 0), "R1");
        end
        step(16'h0000, 16'h0000, 1'b0, 1'b0, "R9");
        step(16'h0000, 16'h0000, 1'b0, 1'b0, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule